// File: doc/BRIEF.md
# Deadband Skew Up/Down Detector

This block decides whether a tuned leaf clock is late, early or close enough relative to a reference clock. Both clock arrivals reach it as single-cycle event strobes that have already been sampled on a fast measurement clock. The block counts the number of measurement ticks between the two strobes and gives the count a sign: the leaf lags when the reference strobe comes first, and it leads when the leaf strobe comes first. It then compares the size of that offset against a skew threshold.

When the leaf lags by more than the threshold, the block requests a later-to-earlier correction on `up_o`. When the leaf leads by more than the threshold, it requests the opposite correction on `down_o`. An offset inside the band gives `lock_o` and no request. The threshold is programmable. If it is programmed to zero, the block uses one and a half tuning steps instead. With this deadband, one correction step can never push the skew across the opposite edge of the band, so the loop does not oscillate.

A measurement opens on the first strobe and closes on the first strobe of the other kind. If the closing strobe does not arrive within a fixed timeout, the measurement is dropped and the decision outputs are cleared. The verdict stays registered until the next result, and `valid_o` marks each new result with a one-cycle pulse.

Top module: `skew_updown_det`

## Requirements
- R1: While `rst_ni` is low and on the first cycle after it, `up_o`, `down_o`, `lock_o` and `valid_o` are 0 and `skew_mag_o` is 0.
- R2: A reference strobe sampled at edge t0 followed by a leaf strobe sampled at edge t0+k (1 <= k <= TMO_CYC, no saturation) gives, right after edge t0+k, `valid_o`=1 and `skew_mag_o`=k, with the leaf treated as lagging.
- R3: A lagging leaf asserts `up_o` only when the offset is strictly greater than the effective threshold. An offset equal to the threshold gives `lock_o`.
- R4: A leaf strobe at t0 followed by a reference strobe at t0+k gives `skew_mag_o`=k with the leaf treated as leading. `down_o` is asserted only when k is strictly greater than the effective threshold; otherwise `lock_o` is asserted.
- R5: `up_o` and `down_o` are never 1 together. On every result exactly one of `up_o`, `down_o`, `lock_o` is 1.
- R6: Reference and leaf strobes sampled on the same edge with no measurement open give a result with `skew_mag_o`=0 and `lock_o`=1.
- R7: When `thr_i` is 0, the effective threshold is `step_i + floor(step_i/2)`, saturated to 2^CNT_W-1. Otherwise it is `thr_i`.
- R8: `valid_o` is high for exactly one cycle per result. The verdict and `skew_mag_o` keep their values until the next result or timeout.
- R9: If no closing strobe has been sampled by the TMO_CYC-th edge after the opening one, the measurement is discarded: `up_o`, `down_o`, `lock_o` and `skew_mag_o` go to 0 and no `valid_o` pulse is produced. A closing strobe on exactly the TMO_CYC-th edge is still accepted.
- R10: The offset count saturates at 2^CNT_W-1 and does not wrap. The decision uses the saturated value.
- R11: While a measurement is open, further strobes of the opening kind are ignored. The offset is counted from the first one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Measurement clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_evt_i | input | 1 | Sampled reference clock edge strobe |
| leaf_evt_i | input | 1 | Sampled leaf clock edge strobe |
| step_i | input | CNT_W | Tuning step size in ticks |
| thr_i | input | CNT_W | Skew threshold in ticks; 0 selects 1.5 steps |
| up_o | output | 1 | Leaf lags beyond threshold |
| down_o | output | 1 | Leaf leads beyond threshold |
| lock_o | output | 1 | Offset within deadband |
| valid_o | output | 1 | One-cycle pulse marking a new result |
| skew_mag_o | output | CNT_W | Saturated offset magnitude of the latest result |

## Verification
The hardest cases to reach are the two ends of the timeout window. A closing strobe on exactly the last accepted tick must still produce a result, and that result must also be saturated. A strobe one tick later must find the measurement already discarded. The bench places the opening and closing strobes on chosen negative edges, so offsets of TMO_CYC and above are set exactly. Before a timeout it first loads an UP verdict, so that the clearing of the outputs can be seen, and it watches `valid_o` on every cycle of the window.

// File: rtl/skew_det_pkg.sv
package skew_det_pkg;
  typedef enum logic [1:0] {
    PH_IDLE      = 2'd0,
    PH_WAIT_LEAF = 2'd1,
    PH_WAIT_REF  = 2'd2
  } pair_ph_e;

  typedef struct packed {
    logic up;
    logic dn;
    logic lock;
  } verdict_t;
endpackage

// File: rtl/skew_pair_fsm.sv
module skew_pair_fsm
  import skew_det_pkg::*;
#(
  parameter int unsigned TMO_CYC = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_evt_i,
  input  logic leaf_evt_i,
  output logic start_o,
  output logic run_o,
  output logic close_o,
  output logic lead_o,
  output logic zero_o,
  output logic abort_o
);
  localparam int unsigned TMR_W = $clog2(TMO_CYC + 1);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(TMO_CYC);

  pair_ph_e ph_q, ph_d;
  logic [TMR_W-1:0] tmr_q;
  logic tmr_end;

  assign tmr_end = (tmr_q == TMR_LAST);

  always_comb begin
    ph_d    = ph_q;
    start_o = 1'b0;
    run_o   = 1'b0;
    close_o = 1'b0;
    lead_o  = 1'b0;
    zero_o  = 1'b0;
    abort_o = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        if (ref_evt_i && leaf_evt_i) begin
          close_o = 1'b1;
          zero_o  = 1'b1;
        end else if (ref_evt_i) begin
          start_o = 1'b1;
          ph_d    = PH_WAIT_LEAF;
        end else if (leaf_evt_i) begin
          start_o = 1'b1;
          ph_d    = PH_WAIT_REF;
        end
      end
      PH_WAIT_LEAF: begin
        if (leaf_evt_i) begin
          close_o = 1'b1;
          ph_d    = PH_IDLE;
        end else if (tmr_end) begin
          abort_o = 1'b1;
          ph_d    = PH_IDLE;
        end else begin
          run_o = 1'b1;
        end
      end
      PH_WAIT_REF: begin
        if (ref_evt_i) begin
          close_o = 1'b1;
          lead_o  = 1'b1;
          ph_d    = PH_IDLE;
        end else if (tmr_end) begin
          abort_o = 1'b1;
          ph_d    = PH_IDLE;
        end else begin
          run_o = 1'b1;
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_IDLE;
      tmr_q <= '0;
    end else begin
      ph_q <= ph_d;
      if (start_o)    tmr_q <= TMR_W'(1);
      else if (run_o) tmr_q <= tmr_q + TMR_W'(1);
    end
  end
endmodule

// File: rtl/skew_offset_cnt.sv
module skew_offset_cnt #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             run_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;

  // saturate instead of wrapping
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (start_i) begin
      cnt_q <= CNT_W'(1);
    end else if (run_i && (cnt_q != CNT_MAX)) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/skew_thr_cmp.sv
module skew_thr_cmp
  import skew_det_pkg::*;
#(
  parameter int unsigned CNT_W = 6
) (
  input  logic [CNT_W-1:0] mag_i,
  input  logic             lead_i,
  input  logic [CNT_W-1:0] step_i,
  input  logic [CNT_W-1:0] thr_i,
  output verdict_t         verdict_o
);
  localparam logic [CNT_W-1:0] THR_MAX = '1;

  logic [CNT_W:0]   dflt_sum;
  logic [CNT_W-1:0] thr_eff;
  logic             outside;

  // zero threshold selects 1.5 steps
  assign dflt_sum = {1'b0, step_i} + {2'b00, step_i[CNT_W-1:1]};
  assign thr_eff  = (thr_i != '0) ? thr_i
                  : (dflt_sum[CNT_W] ? THR_MAX : dflt_sum[CNT_W-1:0]);
  assign outside  = (mag_i > thr_eff);

  always_comb begin
    verdict_o.up   = outside && !lead_i;
    verdict_o.dn   = outside && lead_i;
    verdict_o.lock = !outside;
  end
endmodule

// File: rtl/skew_updown_det.sv
module skew_updown_det
  import skew_det_pkg::*;
#(
  parameter int unsigned CNT_W   = 6,
  parameter int unsigned TMO_CYC = 100
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_evt_i,
  input  logic             leaf_evt_i,
  input  logic [CNT_W-1:0] step_i,
  input  logic [CNT_W-1:0] thr_i,
  output logic             up_o,
  output logic             down_o,
  output logic             lock_o,
  output logic             valid_o,
  output logic [CNT_W-1:0] skew_mag_o
);
  logic start, run, close, lead, zero, abort;
  logic [CNT_W-1:0] cnt, mag;
  verdict_t verdict, verdict_q;
  logic valid_q;
  logic [CNT_W-1:0] mag_q;

  skew_pair_fsm #(.TMO_CYC(TMO_CYC)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ref_evt_i (ref_evt_i),
    .leaf_evt_i(leaf_evt_i),
    .start_o   (start),
    .run_o     (run),
    .close_o   (close),
    .lead_o    (lead),
    .zero_o    (zero),
    .abort_o   (abort)
  );

  skew_offset_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start),
    .run_i  (run),
    .cnt_o  (cnt)
  );

  assign mag = zero ? '0 : cnt;

  skew_thr_cmp #(.CNT_W(CNT_W)) u_cmp (
    .mag_i    (mag),
    .lead_i   (lead),
    .step_i   (step_i),
    .thr_i    (thr_i),
    .verdict_o(verdict)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      verdict_q <= '0;
      mag_q     <= '0;
      valid_q   <= 1'b0;
    end else begin
      valid_q <= close;
      if (close) begin
        verdict_q <= verdict;
        mag_q     <= mag;
      end else if (abort) begin
        verdict_q <= '0;
        mag_q     <= '0;
      end
    end
  end

  assign up_o       = verdict_q.up;
  assign down_o     = verdict_q.dn;
  assign lock_o     = verdict_q.lock;
  assign valid_o    = valid_q;
  assign skew_mag_o = mag_q;
endmodule

// File: rtl/skew_updown_det_chk.sv
module skew_updown_det_chk #(
  parameter int unsigned CNT_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] thr_i,
  input logic             up_o,
  input logic             down_o,
  input logic             lock_o,
  input logic             valid_o,
  input logic [CNT_W-1:0] skew_mag_o
);
  AST_UP_DN_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(up_o && down_o)); // R5

  AST_ONE_VERDICT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ($countones({up_o, down_o, lock_o}) == 1)); // R5

  AST_ZERO_LOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && (skew_mag_o == '0)) |-> lock_o); // R6

  AST_LOCK_IN_BAND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && lock_o && ($past(thr_i) != '0)) |-> (skew_mag_o <= $past(thr_i))); // R3

  AST_REQ_OUT_BAND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && (up_o || down_o) && ($past(thr_i) != '0)) |-> (skew_mag_o > $past(thr_i))); // R4

  AST_HOLD_VERDICT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_o && (up_o || down_o || lock_o)) |-> $stable({up_o, down_o, lock_o, skew_mag_o})); // R8
endmodule

bind skew_updown_det skew_updown_det_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .thr_i     (thr_i),
  .up_o      (up_o),
  .down_o    (down_o),
  .lock_o    (lock_o),
  .valid_o   (valid_o),
  .skew_mag_o(skew_mag_o)
);

// File: tb/sim_skew_updown_det.sv
`timescale 1ns/1ps
module sim_skew_updown_det;
  localparam int unsigned CNT_W   = 6;
  localparam int unsigned TMO_CYC = 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_evt = 1'b0;
  logic leaf_evt = 1'b0;
  logic [CNT_W-1:0] step = '0;
  logic [CNT_W-1:0] thr = '0;
  logic up, down, lock, valid;
  logic [CNT_W-1:0] mag;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  skew_updown_det #(.CNT_W(CNT_W), .TMO_CYC(TMO_CYC)) u0 (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .ref_evt_i (ref_evt),
    .leaf_evt_i(leaf_evt),
    .step_i    (step),
    .thr_i     (thr),
    .up_o      (up),
    .down_o    (down),
    .lock_o    (lock),
    .valid_o   (valid),
    .skew_mag_o(mag)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input int v, input int m,
                         input int u, input int d, input int l);
    chk({req, " valid"}, int'(valid), v);
    chk({req, " mag"},   int'(mag), m);
    chk({req, " up"},    int'(up), u);
    chk({req, " down"},  int'(down), d);
    chk({req, " lock"},  int'(lock), l);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ref_evt = 1'b0; leaf_evt = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // first=1: reference opens; k ticks to closing strobe; returns at negedge after close
  task automatic measure(input bit ref_first, input int k);
    @(negedge clk);
    if (k == 0) begin
      ref_evt = 1'b1; leaf_evt = 1'b1;
      @(negedge clk);
      ref_evt = 1'b0; leaf_evt = 1'b0;
      return;
    end
    if (ref_first) ref_evt = 1'b1; else leaf_evt = 1'b1;
    @(negedge clk);
    ref_evt = 1'b0; leaf_evt = 1'b0;
    repeat (k - 1) @(negedge clk);
    if (ref_first) leaf_evt = 1'b1; else ref_evt = 1'b1;
    @(negedge clk);
    ref_evt = 1'b0; leaf_evt = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    #5;
    chk_out("R1 in reset", 0, 0, 0, 0, 0);
    do_reset();
    chk_out("R1 after reset", 0, 0, 0, 0, 0);
  endtask

  task automatic t_lag();
    thr = 6'd5; step = 6'd4;
    measure(1'b1, 3);
    chk_out("R2 lag 3", 1, 3, 0, 0, 1);
    measure(1'b1, 5);
    chk_out("R3 lag eq thr", 1, 5, 0, 0, 1);
    measure(1'b1, 6);
    chk_out("R3 lag thr+1", 1, 6, 1, 0, 0);
    measure(1'b1, 1);
    chk_out("R2 lag 1", 1, 1, 0, 0, 1);
  endtask

  task automatic t_lead();
    thr = 6'd5;
    measure(1'b0, 5);
    chk_out("R4 lead eq thr", 1, 5, 0, 0, 1);
    measure(1'b0, 9);
    chk_out("R4 lead 9", 1, 9, 0, 1, 0);
    chk("R5 not both", int'(up && down), 0);
  endtask

  task automatic t_simul();
    thr = 6'd1;
    measure(1'b0, 9);
    measure(1'b1, 0);
    chk_out("R6 same edge", 1, 0, 0, 0, 1);
  endtask

  task automatic t_default_thr();
    thr = 6'd0; step = 6'd4;
    measure(1'b1, 6);
    chk_out("R7 dflt eq", 1, 6, 0, 0, 1);
    measure(1'b1, 7);
    chk_out("R7 dflt above", 1, 7, 1, 0, 0);
    step = 6'd5;
    measure(1'b0, 8);
    chk_out("R7 odd step", 1, 8, 0, 1, 0);
    step = 6'd63;
    measure(1'b1, 70);
    chk_out("R7 dflt saturated", 1, 63, 0, 0, 1);
  endtask

  task automatic t_hold();
    thr = 6'd2;
    measure(1'b1, 4);
    chk_out("R8 result", 1, 4, 1, 0, 0);
    thr = 6'd20;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk_out("R8 hold", 0, 4, 1, 0, 0);
    end
  endtask

  task automatic t_saturate();
    thr = 6'd10;
    measure(1'b1, 70);
    chk_out("R10 sat lag", 1, 63, 1, 0, 0);
    measure(1'b0, 64);
    chk_out("R10 sat at wrap", 1, 63, 0, 1, 0);
    measure(1'b1, TMO_CYC);
    chk_out("R9 close on last tick", 1, 63, 1, 0, 0);
  endtask

  task automatic t_timeout();
    int vseen;
    thr = 6'd2;
    measure(1'b1, 8);
    chk_out("R9 preload", 1, 8, 1, 0, 0);
    vseen = 0;
    ref_evt = 1'b1;
    @(negedge clk);
    ref_evt = 1'b0;
    for (int i = 0; i < TMO_CYC + 5; i++) begin
      @(negedge clk);
      if (valid) vseen++;
    end
    chk("R9 no valid", vseen, 0);
    chk_out("R9 cleared", 0, 0, 0, 0, 0);
    // stale measurement gone: leaf now opens a new one
    measure(1'b0, 4);
    chk_out("R9 new after tmo", 1, 4, 0, 1, 0);
    // one tick late: leaf at TMO+1 becomes an opener
    measure(1'b1, TMO_CYC + 1);
    chk_out("R9 late close", 0, 0, 0, 0, 0);
    do_reset();
  endtask

  task automatic t_repeat_open();
    thr = 6'd3;
    @(negedge clk);
    ref_evt = 1'b1;
    @(negedge clk);
    ref_evt = 1'b0;
    repeat (2) @(negedge clk);
    ref_evt = 1'b1;
    @(negedge clk);
    ref_evt = 1'b0;
    repeat (4) @(negedge clk);
    leaf_evt = 1'b1;
    @(negedge clk);
    leaf_evt = 1'b0;
    chk_out("R11 repeat ref ignored", 1, 8, 1, 0, 0);
  endtask

  initial begin
    t_reset();
    t_lag();
    t_lead();
    t_simul();
    t_default_thr();
    t_hold();
    t_saturate();
    t_timeout();
    t_repeat_open();
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule